// File: doc/BRIEF.md
# Descriptor-Driven Fly-By DMA Channel

This block is one DMA channel that moves a run of bytes between system memory and a peripheral byte stream in a single pass, with no software-visible staging buffer. Software places a four-word descriptor in memory, loads its address into the channel's descriptor pointer and sets the run bit. The channel fetches the descriptor, moves the bytes, marks the descriptor as finished in memory, and then follows the link to the next descriptor or stops.

The memory start address may fall on any byte and the byte count may be any value up to the counter width. Towards the peripheral, each fetched word is aligned to its start lane and shifted out a byte at a time. From the peripheral, bytes are steered into their lanes and a word write goes out only when a word is full or the last byte has arrived, with byte enables covering exactly the bytes written. On a channel built as external, a device-select bit in the descriptor chooses both the peripheral port and the direction. On other channels the direction comes from a parameter and the bit is ignored.

Top module: `flyby_dma_chan`

## Requirements
- R1: After reset, control, status, descriptor pointer and next pointer read 0, the status mask reads 0x7, and `mem_req`, `out_valid`, `in_ready` and `irq` are low.
- R2: Register word index 0 is control (bit 0 run), 1 is status (bit 0 done, bit 1 halted, bit 2 aborted), 2 is the status mask (bits 2:0, 1 = masked), 3 is the descriptor pointer and 4 is the next descriptor pointer. Pointers hold bits 31:2, and bits 1:0 read 0.
- R3: While the channel is idle with run set, it reads the descriptor words at pointer +0, +4, +8 and +12. Word 0 holds the byte count in bits 17:0, the device select in bit 18 and the interrupt-on-done flag in bit 19. Word 1 is the memory byte address. Word 2 appears on `dev_tag`. Word 3 is loaded into the next pointer. `dev_sel` shows the device select.
- R4: With device select 0, the bytes from the memory address upward appear in ascending order on the out stream. Each memory word is read once, at a word-aligned address.
- R5: With device select 1, in-stream bytes are written to memory in ascending address order. A write is issued when lane 3 is filled or the last byte has arrived, and byte-enable bit k marks byte lane k (bits 8k+7:8k) of that word.
- R6: The address advances linearly by one per byte, including across a 64 KB boundary.
- R7: After the last byte, the channel writes bit 31 of descriptor word 0 with `mem_be` = 4'b1000. The done status bit is set only if the descriptor's interrupt-on-done flag is 1.
- R8: After that write, a nonzero next pointer is copied into the descriptor pointer and the next descriptor is fetched. Otherwise the halted bit is set and run is cleared.
- R9: Clearing run during a transfer stops the channel at the next memory word boundary and sets the aborted bit. No descriptor write-back and no further memory requests follow.
- R10: Writing 1 to a status bit clears it. `irq` is high exactly when a status bit is set whose mask bit is 0.
- R11: A descriptor with byte count 0 performs no data access and goes directly to the write-back.
- R12: `mem_req` holds its address and direction until `mem_ack`. `out_valid` holds with unchanged data until `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Write byte enables, one per lane |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Byte to the peripheral is valid |
| out_data | output | 8 | Byte to the peripheral |
| out_ready | input | 1 | Peripheral accepts the byte |
| in_valid | input | 1 | Byte from the peripheral is valid |
| in_data | input | 8 | Byte from the peripheral |
| in_ready | output | 1 | Channel accepts the byte |
| dev_sel | output | 1 | Device select of the active descriptor |
| dev_tag | output | 32 | Device word of the active descriptor |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an abort: run has to be cleared while bytes are still moving, and the stop must land on a word boundary rather than mid-word or after the write-back. The bench starts a long transfer with an irregular `out_ready` pattern and drops run once a few bytes have been seen. It then checks that the byte total is a whole number of words, that the descriptor stays unmarked and that the memory side falls silent. Partial first and last words, a chained zero-length descriptor and a 64 KB crossing are reached by choosing descriptor addresses and counts directly in the bench's memory model.

// File: rtl/flyby_dma_pkg.sv
// Shared constants and types for the fly-by DMA channel.
// Assumes a 32-bit register and memory data path.
package flyby_dma_pkg;

    localparam int REG_W    = 32;
    localparam int PTR_LSB  = 2;
    localparam int ST_BITS  = 3;
    localparam int DONE_BIT = 31;

    // Status bit positions
    localparam int ST_DONE  = 0;
    localparam int ST_HALT  = 1;
    localparam int ST_ABORT = 2;

    // Register word indices
    localparam logic [2:0] RI_CTRL  = 3'd0;
    localparam logic [2:0] RI_STAT  = 3'd1;
    localparam logic [2:0] RI_MASK  = 3'd2;
    localparam logic [2:0] RI_DPTR  = 3'd3;
    localparam logic [2:0] RI_NDPTR = 3'd4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_RD_REQ,
        S_EMIT,
        S_GATHER,
        S_WR_REQ,
        S_WBACK
    } chan_state_t;

endpackage

// File: rtl/flyby_dma_regs.sv
// Register set of one DMA channel: control, status (write-one-to-clear),
// status mask, descriptor pointer and next descriptor pointer.
// Assumes one register access per cycle. Hardware events may arrive in
// the same cycle as a software write. A software write wins on
// control and the pointers, and a set event wins on status.
module flyby_dma_regs
    import flyby_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       idx,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             done_evt,
    input  logic             halt_evt,
    input  logic             abort_evt,
    input  logic             chain_load,
    input  logic             link_load,
    input  logic [REG_W-1:0] link_val,
    output logic             run,
    output logic [REG_W-1:0] dptr,
    output logic [REG_W-1:0] ndptr,
    output logic             irq
);

    localparam int PW = REG_W - PTR_LSB;

    logic [ST_BITS-1:0] stat_q, mask_q, stat_set, stat_clr;
    logic [PW-1:0]      dptr_q, ndptr_q;
    logic               wr_ctrl, wr_stat;

    assign wr_ctrl  = wr_en && (idx == RI_CTRL);
    assign wr_stat  = wr_en && (idx == RI_STAT);
    assign stat_set = {abort_evt, halt_evt, done_evt};
    assign stat_clr = wr_stat ? wdata[ST_BITS-1:0] : '0;

    // Run bit: software sets or clears it; the end of a chain clears it
    always_ff @(posedge clk) begin
        if (!rst_n)       run <= 1'b0;
        else if (wr_ctrl) run <= wdata[0];
        else if (halt_evt) run <= 1'b0;
    end

    // Status: sticky events, cleared by writing ones
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | stat_set;
    end

    // Mask: all sources masked after reset
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '1;
        else if (wr_en && idx == RI_MASK)    mask_q <= wdata[ST_BITS-1:0];
    end

    // Descriptor pointer: software load or chain advance
    always_ff @(posedge clk) begin
        if (!rst_n)                       dptr_q <= '0;
        else if (wr_en && idx == RI_DPTR) dptr_q <= wdata[REG_W-1:PTR_LSB];
        else if (chain_load)              dptr_q <= ndptr_q;
    end

    // Next pointer: software load or link word of a fetched descriptor
    always_ff @(posedge clk) begin
        if (!rst_n)                        ndptr_q <= '0;
        else if (wr_en && idx == RI_NDPTR) ndptr_q <= wdata[REG_W-1:PTR_LSB];
        else if (link_load)                ndptr_q <= link_val[REG_W-1:PTR_LSB];
    end

    assign dptr  = {dptr_q,  {PTR_LSB{1'b0}}};
    assign ndptr = {ndptr_q, {PTR_LSB{1'b0}}};
    assign irq   = |(stat_q & ~mask_q);

    // Read mux over the five registers
    always_comb begin
        rdata = '0;
        case (idx)
            RI_CTRL:  rdata[0] = run;
            RI_STAT:  rdata[ST_BITS-1:0] = stat_q;
            RI_MASK:  rdata[ST_BITS-1:0] = mask_q;
            RI_DPTR:  rdata = dptr;
            RI_NDPTR: rdata = ndptr;
            default:  rdata = '0;
        endcase
    end

    assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[ST_BITS-1:0] == '1 && stat_set == '0) |=> (stat_q == '0));

    assert_halt_stops_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_evt && !wr_ctrl) |=> !run);

endmodule

// File: rtl/flyby_dma_align.sv
// Byte realignment buffer for one memory word.
// Read direction: a loaded word is shifted down to its start lane, then
// moved one byte per shift. Write direction: bytes are steered into
// the lane given by the address, and a byte enable is kept per lane.
// Assumes at most one operation per cycle.
module flyby_dma_align #(
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    input  logic                     load,
    input  logic [DATA_W-1:0]        load_data,
    input  logic                     shift,
    input  logic                     put,
    input  logic [7:0]               put_byte,
    input  logic                     flush,
    output logic [7:0]               out_byte,
    output logic [DATA_W-1:0]        word_data,
    output logic [DATA_W/8-1:0]      word_be
);

    localparam int BYTES  = DATA_W / 8;
    localparam int LANE_W = $clog2(BYTES);

    logic [DATA_W-1:0] buf_q, ld_aligned, buf_down;
    logic [BYTES-1:0]  be_q;

    assign ld_aligned = load_data >> {lane, 3'b000};
    assign buf_down   = buf_q >> 8;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        // One byte lane: load, shift down, or capture a steered byte
        always_ff @(posedge clk) begin
            if (!rst_n)                                   buf_q[g*8 +: 8] <= '0;
            else if (load)                                buf_q[g*8 +: 8] <= ld_aligned[g*8 +: 8];
            else if (shift)                               buf_q[g*8 +: 8] <= buf_down[g*8 +: 8];
            else if (put && lane == LANE_W'(g))           buf_q[g*8 +: 8] <= put_byte;
        end

        // Byte enable of this lane: set on capture, cleared on flush
        always_ff @(posedge clk) begin
            if (!rst_n || flush)                          be_q[g] <= 1'b0;
            else if (put && lane == LANE_W'(g))           be_q[g] <= 1'b1;
        end
    end

    assign out_byte  = buf_q[7:0];
    assign word_data = buf_q;
    assign word_be   = be_q;

    assert_single_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({load, shift, put, flush}) <= 1);

endmodule

// File: rtl/flyby_dma_chan.sv
// One fly-by DMA channel. It fetches a four-word descriptor, moves bytes
// between memory and a peripheral byte stream with byte realignment,
// writes a done bit back to the descriptor and follows the link.
// Assumes a memory port that holds a request until a one-cycle ack,
// with read data valid during the ack. Data width is 32 bits.
module flyby_dma_chan
    import flyby_dma_pkg::*;
#(
    parameter int CNT_W     = 18,
    parameter bit EXTERNAL  = 1'b1,
    parameter bit FIXED_P2M = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [3:0]       mem_be,
    output logic [REG_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [REG_W-1:0] mem_rdata,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             dev_sel,
    output logic [REG_W-1:0] dev_tag,
    output logic             irq
);

    localparam int BYTES   = REG_W / 8;
    localparam int LANE_W  = $clog2(BYTES);
    localparam int DS_BIT  = CNT_W;
    localparam int IOC_BIT = CNT_W + 1;

    chan_state_t        state_q, state_d;
    logic [1:0]         widx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [REG_W-1:0]   addr_q, wr_waddr_q, tag_q;
    logic               ds_q, ioc_q, p2m;
    logic               run;
    logic [REG_W-1:0]   dptr, ndptr;
    logic               done_evt, halt_evt, abort_evt, chain_load, link_load;
    logic               al_load, al_shift, al_put, al_flush;
    logic [LANE_W-1:0]  lane;
    logic               last_lane;
    logic [7:0]         al_byte;
    logic [REG_W-1:0]   al_word;
    logic [BYTES-1:0]   al_be;

    assign lane      = addr_q[LANE_W-1:0];
    assign last_lane = &lane;

    // Direction source: descriptor bit on external channels, parameter otherwise
    if (EXTERNAL) begin : g_ext
        assign p2m     = ds_q;
        assign dev_sel = ds_q;
    end else begin : g_int
        assign p2m     = FIXED_P2M;
        assign dev_sel = 1'b0;
    end

    assign dev_tag  = tag_q;
    assign out_data = al_byte;

    flyby_dma_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .idx        (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .done_evt   (done_evt),
        .halt_evt   (halt_evt),
        .abort_evt  (abort_evt),
        .chain_load (chain_load),
        .link_load  (link_load),
        .link_val   (mem_rdata),
        .run        (run),
        .dptr       (dptr),
        .ndptr      (ndptr),
        .irq        (irq)
    );

    flyby_dma_align #(.DATA_W(REG_W)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane      (lane),
        .load      (al_load),
        .load_data (mem_rdata),
        .shift     (al_shift),
        .put       (al_put),
        .put_byte  (in_data),
        .flush     (al_flush),
        .out_byte  (al_byte),
        .word_data (al_word),
        .word_be   (al_be)
    );

    // Channel sequencer: drives memory, stream handshakes and events
    always_comb begin
        state_d    = state_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_be     = '0;
        mem_wdata  = '0;
        out_valid  = 1'b0;
        in_ready   = 1'b0;
        done_evt   = 1'b0;
        halt_evt   = 1'b0;
        abort_evt  = 1'b0;
        chain_load = 1'b0;
        link_load  = 1'b0;
        al_load    = 1'b0;
        al_shift   = 1'b0;
        al_put     = 1'b0;
        al_flush   = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (run) state_d = S_FETCH;
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = dptr + {{(REG_W-4){1'b0}}, widx_q, 2'b00};
                if (mem_ack && widx_q == 2'd3) begin
                    link_load = 1'b1;
                    if (cnt_q == '0) state_d = S_WBACK;
                    else if (p2m)    state_d = S_GATHER;
                    else             state_d = S_RD_REQ;
                end
            end
            S_RD_REQ: begin
                mem_req  = 1'b1;
                mem_addr = {addr_q[REG_W-1:LANE_W], {LANE_W{1'b0}}};
                if (mem_ack) begin
                    al_load = 1'b1;
                    state_d = S_EMIT;
                end
            end
            S_EMIT: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    al_shift = 1'b1;
                    if (cnt_q == CNT_W'(1)) state_d = S_WBACK;
                    else if (last_lane) begin
                        if (run) state_d = S_RD_REQ;
                        else begin
                            abort_evt = 1'b1;
                            state_d   = S_IDLE;
                        end
                    end
                end
            end
            S_GATHER: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    al_put = 1'b1;
                    if (last_lane || cnt_q == CNT_W'(1)) state_d = S_WR_REQ;
                end
            end
            S_WR_REQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wr_waddr_q;
                mem_be    = al_be;
                mem_wdata = al_word;
                if (mem_ack) begin
                    al_flush = 1'b1;
                    if (cnt_q == '0) state_d = S_WBACK;
                    else if (!run) begin
                        abort_evt = 1'b1;
                        state_d   = S_IDLE;
                    end else state_d = S_GATHER;
                end
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dptr;
                mem_be    = 4'b1000;
                mem_wdata = REG_W'(1) << DONE_BIT;
                if (mem_ack) begin
                    done_evt = ioc_q;
                    if (ndptr != '0) begin
                        chain_load = 1'b1;
                        state_d    = S_FETCH;
                    end else begin
                        halt_evt = 1'b1;
                        state_d  = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Descriptor word index, restarted on every entry to fetch
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != S_FETCH) widx_q <= '0;
        else if (mem_ack)                 widx_q <= widx_q + 2'd1;
    end

    // Descriptor fields, byte counter and linear address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            addr_q     <= '0;
            tag_q      <= '0;
            ds_q       <= 1'b0;
            ioc_q      <= 1'b0;
            wr_waddr_q <= '0;
        end else if (state_q == S_FETCH && mem_ack) begin
            case (widx_q)
                2'd0: begin
                    cnt_q <= mem_rdata[CNT_W-1:0];
                    ds_q  <= mem_rdata[DS_BIT];
                    ioc_q <= mem_rdata[IOC_BIT];
                end
                2'd1:    addr_q <= mem_rdata;
                2'd2:    tag_q  <= mem_rdata;
                default: ;
            endcase
        end else if (al_shift || al_put) begin
            cnt_q  <= cnt_q - CNT_W'(1);
            addr_q <= addr_q + REG_W'(1);
            if (al_put) wr_waddr_q <= {addr_q[REG_W-1:LANE_W], {LANE_W{1'b0}}};
        end
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_write_has_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != '0));

    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LANE_W-1:0] == '0));

    assert_one_direction_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && in_ready));

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> !mem_req);

endmodule

// File: tb/flyby_dma_chan_bench.sv
// Directed bench for the fly-by DMA channel.
module flyby_dma_chan_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        dev_sel;
    logic [31:0] dev_tag;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int hs_viol = 0;
    bit stall_en = 1'b0;

    bit [31:0] mem [bit [31:0]];
    bit [31:0] rd_log[$];
    bit [31:0] wr_addr_log[$];
    bit [3:0]  wr_be_log[$];
    bit [7:0]  got[$];
    bit [7:0]  src[$];
    int        src_idx = 0;
    bit        in_fire_q = 1'b0;
    bit        prev_ov = 1'b0, prev_or = 1'b0;
    bit [7:0]  prev_od = '0;

    flyby_dma_chan u_flyby_dma_chan (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .dev_sel(dev_sel), .dev_tag(dev_tag), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit [31:0] rdw(input bit [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic bit [7:0] pat(input bit [31:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic bit [31:0] cmd(input int cnt, input bit ds, input bit ioc);
        return 32'(cnt) | (32'(ds) << 18) | (32'(ioc) << 19);
    endfunction

    // Memory model: one-cycle ack, captures requests at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (mem_ack) mem_ack = 1'b0;
        else if (rst_n && mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                bit [31:0] w;
                w = rdw(mem_addr);
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) w[k*8 +: 8] = mem_wdata[k*8 +: 8];
                mem[mem_addr] = w;
                wr_addr_log.push_back(mem_addr);
                wr_be_log.push_back(mem_be);
            end else begin
                mem_rdata = rdw(mem_addr);
                rd_log.push_back(mem_addr);
            end
        end
    end

    // Out-stream sink with optional stall pattern and hold monitor
    always @(negedge clk) begin
        if (prev_ov && !prev_or && (!out_valid || out_data != prev_od)) hs_viol++;
        out_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
        if (out_valid && out_ready) got.push_back(out_data);
        prev_ov = out_valid;
        prev_or = out_ready;
        prev_od = out_data;
    end

    // In-stream source driven from the src queue
    always @(negedge clk) begin
        if (in_fire_q) src_idx++;
        in_valid  = (src_idx < src.size());
        in_data   = in_valid ? src[src_idx] : 8'h00;
        in_fire_q = in_valid && in_ready;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_addr = idx;
        #1 d = reg_rdata;
    endtask

    task automatic wait_stop(output logic [31:0] st);
        int n = 0;
        st = '0;
        while ((st & 32'h6) == 0 && n < 4000) begin
            reg_rd(3'd1, st);
            n++;
        end
    endtask

    task automatic clear_logs();
        rd_log.delete(); wr_addr_log.delete(); wr_be_log.delete(); got.delete();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(3'd0, v); chk("R1 ctrl", v, 0);
        reg_rd(3'd1, v); chk("R1 status", v, 0);
        reg_rd(3'd2, v); chk("R1 mask", v, 32'h7);
        reg_rd(3'd3, v); chk("R1 dptr", v, 0);
        reg_rd(3'd4, v); chk("R1 ndptr", v, 0);
        chk("R1 outputs idle", {mem_req, out_valid, in_ready, irq}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_wr(3'd2, 32'h5); reg_rd(3'd2, v); chk("R2 mask readback", v, 32'h5);
        reg_wr(3'd4, 32'h1237); reg_rd(3'd4, v); chk("R2 ndptr low bits", v, 32'h1234);
        reg_wr(3'd4, 32'h0); reg_wr(3'd2, 32'h7);
    endtask

    task automatic t_m2p_unaligned();
        logic [31:0] v;
        for (int w = 32'h200; w < 32'h210; w += 4)
            mem[w] = {pat(w+3), pat(w+2), pat(w+1), pat(w)};
        mem[32'h100] = cmd(7, 1'b0, 1'b1);
        mem[32'h104] = 32'h203;
        mem[32'h108] = 32'hCAFE;
        mem[32'h10C] = 32'h0;
        clear_logs(); stall_en = 1'b1;
        reg_wr(3'd3, 32'h100);
        reg_wr(3'd0, 32'h1);
        wait_stop(v);
        chk("R4 byte total", got.size(), 7);
        for (int i = 0; i < 7; i++)
            if (i < got.size()) chk("R4 byte value", got[i], pat(32'h203 + i));
        chk("R4 read count", rd_log.size(), 7);
        if (rd_log.size() == 7) begin
            chk("R3 fetch word 3 address", rd_log[3], 32'h10C);
            chk("R4 first data word", rd_log[4], 32'h200);
            chk("R4 last data word", rd_log[6], 32'h208);
        end
        chk("R3 dev_tag", dev_tag, 32'hCAFE);
        chk("R3 dev_sel", dev_sel, 0);
        chk("R7 done bit written", rdw(32'h100) >> 31, 1);
        chk("R7 writeback be", wr_be_log.size() > 0 ? wr_be_log[0] : 4'h0, 4'b1000);
        chk("R8 status done+halted", v, 32'h3);
        reg_rd(3'd0, v); chk("R8 run cleared", v, 0);
        chk("R12 out stream hold", hs_viol, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); chk("R10 irq masked", irq, 0);
        reg_wr(3'd2, 32'h6); #1 chk("R10 irq on done", irq, 1);
        reg_wr(3'd1, 32'h1); reg_rd(3'd1, v); chk("R10 w1c done", v, 32'h2);
        chk("R10 irq after clear", irq, 0);
        reg_wr(3'd2, 32'h5); #1 chk("R10 irq on halted", irq, 1);
        reg_wr(3'd1, 32'h2); reg_rd(3'd1, v); chk("R10 w1c halted", v, 0);
        chk("R10 irq idle", irq, 0);
        reg_wr(3'd2, 32'h7);
    endtask

    task automatic t_p2m_chain();
        logic [31:0] v;
        for (int w = 32'h400; w < 32'h410; w += 4) mem[w] = 32'hEEEEEEEE;
        mem[32'h300] = cmd(9, 1'b1, 1'b0);
        mem[32'h304] = 32'h401;
        mem[32'h308] = 32'h77;
        mem[32'h30C] = 32'h340;
        mem[32'h340] = cmd(0, 1'b1, 1'b1);
        mem[32'h344] = 32'h900;
        mem[32'h348] = 32'h88;
        mem[32'h34C] = 32'h0;
        clear_logs(); stall_en = 1'b0;
        src.delete(); src_idx = 0;
        for (int i = 0; i < 9; i++) src.push_back(8'(8'h10 + i));
        reg_wr(3'd3, 32'h300);
        reg_wr(3'd0, 32'h1);
        wait_stop(v);
        chk("R5 word 0", rdw(32'h400), 32'h121110EE);
        chk("R5 word 1", rdw(32'h404), 32'h16151413);
        chk("R5 word 2", rdw(32'h408), 32'hEEEE1817);
        chk("R5 untouched word", rdw(32'h40C), 32'hEEEEEEEE);
        chk("R11 write count", wr_addr_log.size(), 5);
        if (wr_be_log.size() == 5) begin
            chk("R5 be first", wr_be_log[0], 4'b1110);
            chk("R5 be middle", wr_be_log[1], 4'b1111);
            chk("R5 be last", wr_be_log[2], 4'b0011);
            chk("R11 zero-count writeback addr", wr_addr_log[4], 32'h340);
        end
        chk("R11 no data read for zero count", rd_log.size(), 8);
        chk("R8 first done bit", rdw(32'h300) >> 31, 1);
        chk("R8 chained done bit", rdw(32'h340) >> 31, 1);
        reg_rd(3'd3, v); chk("R8 dptr advanced", v, 32'h340);
        reg_rd(3'd4, v); chk("R3 link loaded", v, 0);
        chk("R3 dev_sel", dev_sel, 1);
        chk("R3 dev_tag second", dev_tag, 32'h88);
        reg_rd(3'd1, v); chk("R7 status after ioc 0 then 1", v, 32'h3);
        reg_wr(3'd1, 32'h7);
    endtask

    task automatic t_boundary();
        logic [31:0] v;
        mem[32'hFFFC]  = {pat(32'hFFFF), pat(32'hFFFE), pat(32'hFFFD), pat(32'hFFFC)};
        mem[32'h10000] = {pat(32'h10003), pat(32'h10002), pat(32'h10001), pat(32'h10000)};
        mem[32'h600] = cmd(6, 1'b0, 1'b0);
        mem[32'h604] = 32'hFFFE;
        mem[32'h608] = 32'h0;
        mem[32'h60C] = 32'h0;
        clear_logs(); stall_en = 1'b0;
        reg_wr(3'd3, 32'h600);
        reg_wr(3'd0, 32'h1);
        wait_stop(v);
        chk("R6 byte total", got.size(), 6);
        for (int i = 0; i < 6; i++)
            if (i < got.size()) chk("R6 byte value", got[i], pat(32'hFFFE + i));
        if (rd_log.size() == 6) chk("R6 second word address", rd_log[5], 32'h10000);
        else chk("R6 read count", rd_log.size(), 6);
        chk("R7 no done status when flag clear", v, 32'h2);
        reg_wr(3'd1, 32'h7);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int n, busy;
        for (int w = 32'h800; w < 32'h828; w += 4)
            mem[w] = {pat(w+3), pat(w+2), pat(w+1), pat(w)};
        mem[32'h700] = cmd(40, 1'b0, 1'b1);
        mem[32'h704] = 32'h800;
        mem[32'h708] = 32'h0;
        mem[32'h70C] = 32'h0;
        clear_logs(); stall_en = 1'b1;
        reg_wr(3'd3, 32'h700);
        reg_wr(3'd0, 32'h1);
        n = 0;
        while (got.size() < 5 && n < 2000) begin @(negedge clk); n++; end
        reg_wr(3'd0, 32'h0);
        wait_stop(v);
        chk("R9 status aborted", v, 32'h4);
        chk("R9 stop on word boundary", got.size() % 4, 0);
        chk("R9 stopped early", got.size() < 40, 1);
        chk("R9 descriptor not marked", rdw(32'h700) >> 31, 0);
        chk("R9 no write-back", wr_addr_log.size(), 0);
        if (got.size() > 4) chk("R4 byte after reload", got[4], pat(32'h804));
        busy = 0;
        repeat (20) begin @(negedge clk); if (mem_req) busy++; end
        chk("R9 memory quiet", busy, 0);
        chk("R12 out stream hold", hs_viol, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_m2p_unaligned();
        t_irq();
        t_p2m_chain();
        t_boundary();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule